// File: doc/BRIEF.md
# Two-Decade Decimal Frequency Divider

This block divides an input clock by a decimal ratio N between 1 and 99. N is given as two BCD digits. Two decade stages are chained: the units stage counts down on every enabled clock, and the tens stage counts down only when the units stage wraps from 0 to 9. When the count reaches 01 on an enabled clock, both stages reload from the ratio word. A one-cycle pulse on `pulse_o` then marks the start of the next period. The result is one output pulse for every N enabled input clocks.

A ratio word that is not a legal two-digit decimal number (either nibble above 9, or the whole word zero) is flagged at once on `bad_ratio_o`. While it is flagged, the counter is held at 00 and no pulses are produced. When the counter is at 00 and a legal ratio is present, the next clock loads the ratio. A new ratio value on `ratio_i` takes effect only at a load, so changing it never cuts the current period short. A synchronous restart input reloads the ratio and begins a fresh period.

Top module: `bcd_divider`

## Requirements
- R1: `ratio_i[3:0]` is the units digit and `ratio_i[7:4]` is the tens digit. `count_o` uses the same layout, and each of its nibbles always stays in 0..9.
- R2: On each clock with `en_i` high and a count above 01, the count drops by one in decimal. The tens digit decrements only when the units digit wraps from 0 to 9 (example: 10 becomes 09).
- R3: On a clock with `en_i` high and count 01, both digits reload from `ratio_i`, and `pulse_o` is high for the one following cycle. With a fixed ratio N in 1..99 and `en_i` held high, pulses are exactly N clocks apart.
- R4: While `en_i` is low (legal ratio, no restart, count not 00), the count holds and `pulse_o` stays low.
- R5: `bad_ratio_o` is high, combinationally, whenever either nibble of `ratio_i` exceeds 9 or `ratio_i` is 00. At the next clock the count becomes 00 and `pulse_o` is low.
- R6: With the count at 00 and a legal ratio, the next clock loads `ratio_i` into the count whatever `en_i` is, and `pulse_o` stays low.
- R7: With `srst_i` high and a legal ratio, the next clock loads `ratio_i` and drives `pulse_o` low. This takes priority over counting and over terminal reload.
- R8: While `rst_ni` is low, the count is 00 and `pulse_o` is low, without waiting for a clock.
- R9: A change of `ratio_i` to another legal value between loads leaves the running count unaffected. The new value is used at the next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous restart: reload ratio, clear pulse |
| en_i | input | 1 | Count enable |
| ratio_i | input | 8 | Divide ratio, two BCD digits (tens in [7:4]) |
| pulse_o | output | 1 | One-cycle pulse, once per N enabled clocks |
| count_o | output | 8 | Current count, two BCD digits |
| bad_ratio_o | output | 1 | Ratio word is not a legal value 01..99 |

## Verification
Each result is due at a known time:
- `bad_ratio_o` is combinational, so the bench samples it 1 ns after driving `ratio_i`, before the next edge.
- `count_o` and `pulse_o` are registered, so both change at the first rising edge after the stimulus. The bench samples them 1 ns after that edge, against a decimal model that is updated at the same edge.
- The asynchronous reset is checked 1 ns after `rst_ni` falls, with no edge in between.

Inputs are driven only on falling edges, so no check depends on the order of processes at the rising edge.

// File: rtl/bcd_div_pkg.sv
package bcd_div_pkg;
  localparam int unsigned DIGIT_W   = 4;
  localparam int unsigned MAX_DIGIT = 9;

  typedef logic [DIGIT_W-1:0] digit_t;

  function automatic logic digit_ok(digit_t d);
    return d <= digit_t'(MAX_DIGIT);
  endfunction

  function automatic digit_t digit_dec(digit_t d);
    return (d == '0) ? digit_t'(MAX_DIGIT) : d - digit_t'(1);
  endfunction
endpackage

// File: rtl/bcd_decade_stage.sv
module bcd_decade_stage
  import bcd_div_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clr_i,
  input  logic   load_i,
  input  digit_t load_val_i,
  input  logic   dec_i,
  output digit_t q_o,
  output logic   borrow_o
);
  digit_t q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (clr_i)  q_q <= '0;
    else if (load_i) q_q <= load_val_i;
    else if (dec_i)  q_q <= digit_dec(q_q);
  end

  // wrap 0 -> 9 lends to the next decade
  assign borrow_o = dec_i & (q_q == '0);
  assign q_o      = q_q;
endmodule

// File: rtl/bcd_ratio_check.sv
module bcd_ratio_check
  import bcd_div_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 2,
  localparam int unsigned W = NUM_DIGITS * DIGIT_W
) (
  input  logic [W-1:0] ratio_i,
  output logic         ok_o
);
  logic [NUM_DIGITS-1:0] digit_good;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    assign digit_good[g] = digit_ok(ratio_i[g*DIGIT_W +: DIGIT_W]);
  end

  assign ok_o = (&digit_good) & (|ratio_i);
endmodule

// File: rtl/bcd_term_detect.sv
module bcd_term_detect
  import bcd_div_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 2,
  localparam int unsigned W = NUM_DIGITS * DIGIT_W
) (
  input  logic [W-1:0] count_i,
  output logic         is_zero_o,
  output logic         is_one_o
);
  logic upper_zero;

  always_comb begin
    upper_zero = 1'b1;
    for (int i = 1; i < int'(NUM_DIGITS); i++) begin
      if (count_i[i*DIGIT_W +: DIGIT_W] != '0) upper_zero = 1'b0;
    end
  end

  assign is_zero_o = upper_zero & (count_i[DIGIT_W-1:0] == '0);
  assign is_one_o  = upper_zero & (count_i[DIGIT_W-1:0] == digit_t'(1));
endmodule

// File: rtl/bcd_divider.sv
module bcd_divider
  import bcd_div_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 2,
  localparam int unsigned W = NUM_DIGITS * DIGIT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic         en_i,
  input  logic [W-1:0] ratio_i,
  output logic         pulse_o,
  output logic [W-1:0] count_o,
  output logic         bad_ratio_o
);
  logic          ratio_ok;
  logic          is_zero, is_one;
  logic          run_en, term_hit, load, clr;
  logic [W-1:0]  count_q;
  logic [NUM_DIGITS:0] dec_chain;
  logic          pulse_q;

  bcd_ratio_check #(.NUM_DIGITS(NUM_DIGITS)) u_ratio_check (
    .ratio_i (ratio_i),
    .ok_o    (ratio_ok)
  );

  bcd_term_detect #(.NUM_DIGITS(NUM_DIGITS)) u_term_detect (
    .count_i   (count_q),
    .is_zero_o (is_zero),
    .is_one_o  (is_one)
  );

  assign clr      = ~ratio_ok;
  assign run_en   = ratio_ok & en_i & ~srst_i & ~is_zero;
  assign term_hit = run_en & is_one;
  // borrow out of the top decade would be an underflow: treat it as reload
  assign load     = ratio_ok & (srst_i | is_zero | term_hit | dec_chain[NUM_DIGITS]);
  assign dec_chain[0] = run_en & ~is_one;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_stage
    bcd_decade_stage u_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (clr),
      .load_i     (load),
      .load_val_i (ratio_i[g*DIGIT_W +: DIGIT_W]),
      .dec_i      (dec_chain[g]),
      .q_o        (count_q[g*DIGIT_W +: DIGIT_W]),
      .borrow_o   (dec_chain[g+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= term_hit;
  end

  assign pulse_o     = pulse_q;
  assign count_o     = count_q;
  assign bad_ratio_o = ~ratio_ok;
endmodule

module bcd_divider_chk
  import bcd_div_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 2,
  localparam int unsigned W = NUM_DIGITS * DIGIT_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         srst_i,
  input logic         en_i,
  input logic [W-1:0] ratio_i,
  input logic         pulse_o,
  input logic [W-1:0] count_o,
  input logic         bad_ratio_o
);
  function automatic int dec_val(logic [W-1:0] v);
    int acc = 0;
    for (int i = int'(NUM_DIGITS) - 1; i >= 0; i--) acc = acc * 10 + int'(v[i*DIGIT_W +: DIGIT_W]);
    return acc;
  endfunction

  function automatic logic all_digits_ok(logic [W-1:0] v);
    logic ok = 1'b1;
    for (int i = 0; i < int'(NUM_DIGITS); i++) if (v[i*DIGIT_W +: DIGIT_W] > digit_t'(MAX_DIGIT)) ok = 1'b0;
    return ok;
  endfunction

  // R1
  digits_bcd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_digits_ok(count_o));

  // R2
  dec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !bad_ratio_o && !srst_i && dec_val(count_o) > 1)
    |=> (dec_val(count_o) == dec_val($past(count_o)) - 1) && !pulse_o);

  // R3
  pulse_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> count_o == $past(ratio_i));

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !bad_ratio_o && !srst_i && count_o != '0) |=> $stable(count_o) && !pulse_o);

  // R5
  bad_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_ratio_o |=> count_o == '0 && !pulse_o);

  // R7
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_i && !bad_ratio_o) |=> count_o == $past(ratio_i) && !pulse_o);
endmodule

bind bcd_divider bcd_divider_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (.*);

// File: tb/bcd_divider_bench.sv
`timescale 1ns/1ps
module bcd_divider_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       srst_i = 1'b0;
  logic       en_i = 1'b0;
  logic [7:0] ratio_i = 8'h05;
  logic       pulse_o;
  logic [7:0] count_o;
  logic       bad_ratio_o;

  int    checks = 0;
  int    fails = 0;
  int    exp_cnt = 0;
  bit    exp_pulse = 1'b0;
  string cur_req = "R1";

  always #4 clk_i = ~clk_i;

  bcd_divider u_bcd_divider (.*);

  function automatic logic [7:0] to_bcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic bit legal(logic [7:0] r);
    return (r[3:0] <= 4'd9) && (r[7:4] <= 4'd9) && (r != 8'h00);
  endfunction

  function automatic int ratio_val(logic [7:0] r);
    return int'(r[7:4]) * 10 + int'(r[3:0]);
  endfunction

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    if (!legal(ratio_i))          begin exp_cnt = 0;                  exp_pulse = 0; end
    else if (srst_i)              begin exp_cnt = ratio_val(ratio_i); exp_pulse = 0; end
    else if (exp_cnt == 0)        begin exp_cnt = ratio_val(ratio_i); exp_pulse = 0; end
    else if (en_i && exp_cnt == 1) begin exp_cnt = ratio_val(ratio_i); exp_pulse = 1; end
    else if (en_i)                begin exp_cnt = exp_cnt - 1;        exp_pulse = 0; end
    else                          exp_pulse = 0;
  endtask

  // called just after a falling edge; returns at the next falling edge
  task automatic cycle();
    #1;
    check_eq("R5", "bad_ratio_o", int'(bad_ratio_o), int'(!legal(ratio_i)));
    @(posedge clk_i);
    model_step();
    #1;
    check_eq(cur_req, "count_o", int'(count_o), int'(to_bcd(exp_cnt)));
    check_eq(cur_req, "pulse_o", int'(pulse_o), int'(exp_pulse));
    @(negedge clk_i);
  endtask

  task automatic period_run(logic [7:0] r);
    int gap;
    cur_req = "R3";
    ratio_i = r; srst_i = 1; en_i = 1;
    cycle();
    srst_i = 0;
    for (int k = 0; k < 300 && !pulse_o; k++) cycle();
    gap = 0;
    for (int k = 0; k < 300; k++) begin
      cycle();
      gap++;
      if (pulse_o) break;
    end
    check_eq("R3", "pulse period", gap, ratio_val(r));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'h5EED_0042);
    #1;
    check_eq("R8", "count_o in reset", int'(count_o), 0);
    check_eq("R8", "pulse_o in reset", int'(pulse_o), 0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1;

    // R6: load from 00 with en low
    cur_req = "R6"; ratio_i = 8'h47; en_i = 0;
    cycle();
    check_eq("R1", "digit layout", int'(count_o), 8'h47);

    // R4: hold while disabled
    cur_req = "R4";
    repeat (6) cycle();

    // R2: borrow across digits, 10 -> 09
    cur_req = "R2"; ratio_i = 8'h10; srst_i = 1; cycle(); srst_i = 0;
    en_i = 1; cycle();
    check_eq("R2", "10 to 09", int'(count_o), 8'h09);
    repeat (12) cycle();

    period_run(8'h01);
    period_run(8'h10);
    period_run(8'h99);
    period_run(8'h37);

    // R9: change ratio mid-period
    cur_req = "R9"; ratio_i = 8'h20; srst_i = 1; en_i = 1; cycle(); srst_i = 0;
    repeat (5) cycle();
    ratio_i = 8'h07;
    cycle();
    check_eq("R9", "count unaffected", int'(count_o), 8'h14);
    repeat (30) cycle();

    // R5: illegal ratios
    cur_req = "R5";
    ratio_i = 8'hA5; cycle();
    ratio_i = 8'h3F; cycle();
    ratio_i = 8'h00; cycle(); cycle();
    cur_req = "R6"; ratio_i = 8'h12; en_i = 1; cycle();
    check_eq("R6", "load after illegal", int'(count_o), 8'h12);

    // R7: restart at terminal count overrides the reload pulse
    cur_req = "R7"; ratio_i = 8'h03; en_i = 1;
    repeat (7) cycle();
    while (count_o != 8'h01) cycle();
    srst_i = 1; cycle(); srst_i = 0;
    check_eq("R7", "restart no pulse", int'(pulse_o), 0);

    // R8: async reset mid-run
    cur_req = "R8"; ratio_i = 8'h25; repeat (4) cycle();
    rst_ni = 0; #1;
    check_eq("R8", "async clear count", int'(count_o), 0);
    check_eq("R8", "async clear pulse", int'(pulse_o), 0);
    exp_cnt = 0; exp_pulse = 0;
    @(negedge clk_i); rst_ni = 1;

    // random phase
    cur_req = "R1";
    ratio_i = 8'h23;
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = $urandom % 100;
      if (r < 3) begin
        if (($urandom % 4) == 0) ratio_i = 8'($urandom);
        else ratio_i = to_bcd(1 + int'($urandom % 99));
      end
      en_i   = (($urandom % 10) < 8);
      srst_i = (($urandom % 100) < 2);
      cycle();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule